// File: doc/BRIEF.md
# Address-Masked GPIO Port

An eight-pin general-purpose I/O port with an APB-style register interface. Software sets each pin's direction, enables its digital path, hands it to a peripheral instead of the data register, and picks a pull-up or pull-down. The data register does not live at one address. It fills a 1 KiB window, and address bits [9:2] of each access act as a per-pin mask. A single store can therefore set or clear any subset of pins and leave every other pin untouched, with no read-modify-write sequence that an interrupt could split.

The port drives a per-pin output value and output enable toward the pads. It samples the pads through a two-flop synchronizer. The synchronized, enable-gated inputs go to the data reads and to an output that interrupt logic can watch. A pin whose digital enable is clear is fully inert: it neither drives nor reports anything.

Top module: `gpio_port_regs`

## Requirements
- R1: A write to the data window (offsets 0x000 to 0x3FC, address bits [11:10] both 0) updates only the data bits whose position is set in address bits [9:2]; the other data bits keep their values.
- R2: A read from the data window returns each pin's value ANDed with address bits [9:2], so unaddressed pins read 0. A pin's value is the data register bit for an enabled output pin and the synchronized pad input otherwise.
- R3: The direction register at offset 0x400 has one bit per pin, 1 for output and 0 for input. An enabled output pin drives pad_oe high and puts its data register bit on pad_out.
- R4: The digital-enable register at offset 0x51C resets to 0. While a pin's bit is 0, its pad_oe, pad_out and in_sync bits are 0 and it reads 0 from the data window.
- R5: A set bit in the alternate-select register at offset 0x420 makes that enabled pin take pad_out and pad_oe from alt_out and alt_oe instead of the data and direction registers.
- R6: Pull-up enable (offset 0x510) and pull-down enable (offset 0x514) appear on pad_pu and pad_pd. Writing a 1 to a bit of either register clears the same bit of the other, so both are never set for one pin.
- R7: A change on pad_in reaches in_sync and the data window after the second rising clock edge, not the first.
- R8: Reads of any other offset return 0, and writes to them change no register.
- R9: After reset every register is 0, and pad_out, pad_oe, pad_pu, pad_pd and in_sync are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| psel | input | 1 | Bus select |
| penable | input | 1 | Bus access phase |
| pwrite | input | 1 | 1 for write, 0 for read |
| paddr | input | 12 | Byte address within the port |
| pwdata | input | 32 | Write data |
| prdata | output | 32 | Read data, valid during the access phase |
| pad_in | input | 8 | Raw pad inputs |
| pad_out | output | 8 | Pad output values |
| pad_oe | output | 8 | Pad output enables |
| pad_pu | output | 8 | Pull-up enables |
| pad_pd | output | 8 | Pull-down enables |
| alt_out | input | 8 | Peripheral output values |
| alt_oe | input | 8 | Peripheral output enables |
| in_sync | output | 8 | Synchronized, enable-gated pad inputs |

## Verification
A wrong mask decode shows up in the next cycle as a neighbouring pin changing on pad_out after a single-pin store. The next masked read then returns nonzero bits outside the mask. A missing synchronizer stage shows up on in_sync one edge early. An extra stage shows up as a stale value two edges after pad_in changes. Broken enable gating or pull exclusivity is visible at once on pad_oe, pad_out, pad_pu and pad_pd, without any bus read.

// File: rtl/gpio_port_regs.sv
module gpio_port_regs #(
  parameter int NPINS  = 8,
  parameter int ADDR_W = 12,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              psel,
  input  logic              penable,
  input  logic              pwrite,
  input  logic [ADDR_W-1:0] paddr,
  input  logic [DATA_W-1:0] pwdata,
  output logic [DATA_W-1:0] prdata,
  input  logic [NPINS-1:0]  pad_in,
  output logic [NPINS-1:0]  pad_out,
  output logic [NPINS-1:0]  pad_oe,
  output logic [NPINS-1:0]  pad_pu,
  output logic [NPINS-1:0]  pad_pd,
  input  logic [NPINS-1:0]  alt_out,
  input  logic [NPINS-1:0]  alt_oe,
  output logic [NPINS-1:0]  in_sync
);

  localparam logic [ADDR_W-1:0] OFS_DIR   = ADDR_W'(12'h400);
  localparam logic [ADDR_W-1:0] OFS_ALT   = ADDR_W'(12'h420);
  localparam logic [ADDR_W-1:0] OFS_PU    = ADDR_W'(12'h510);
  localparam logic [ADDR_W-1:0] OFS_PD    = ADDR_W'(12'h514);
  localparam logic [ADDR_W-1:0] OFS_DEN   = ADDR_W'(12'h51C);
  localparam int                MASK_LO   = 2;
  localparam int                MASK_HI   = MASK_LO + NPINS - 1;

  logic [NPINS-1:0] data_q, dir_q, alt_q, pu_q, pd_q, den_q;
  logic [NPINS-1:0] sync1_q, sync2_q;
  logic [NPINS-1:0] amask, wval, pin_val;
  logic [ADDR_W-1:0] word_addr;
  logic wr_en, in_data, hit_dir, hit_alt, hit_pu, hit_pd, hit_den, mapped;

  assign word_addr = {paddr[ADDR_W-1:2], 2'b00};
  assign amask     = paddr[MASK_HI:MASK_LO];
  assign wval      = pwdata[NPINS-1:0];
  assign wr_en     = psel & penable & pwrite;
  assign in_data   = (paddr[ADDR_W-1:10] == '0);
  assign hit_dir   = (word_addr == OFS_DIR);
  assign hit_alt   = (word_addr == OFS_ALT);
  assign hit_pu    = (word_addr == OFS_PU);
  assign hit_pd    = (word_addr == OFS_PD);
  assign hit_den   = (word_addr == OFS_DEN);
  assign mapped    = in_data | hit_dir | hit_alt | hit_pu | hit_pd | hit_den;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      data_q <= '0;
      dir_q  <= '0;
      alt_q  <= '0;
      pu_q   <= '0;
      pd_q   <= '0;
      den_q  <= '0;
    end else if (wr_en) begin
      if (in_data) data_q <= (data_q & ~amask) | (wval & amask);
      if (hit_dir) dir_q  <= wval;
      if (hit_alt) alt_q  <= wval;
      if (hit_den) den_q  <= wval;
      if (hit_pu) begin
        pu_q <= wval;
        pd_q <= pd_q & ~wval;
      end
      if (hit_pd) begin
        pd_q <= wval;
        pu_q <= pu_q & ~wval;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync1_q <= '0;
      sync2_q <= '0;
    end else begin
      sync1_q <= pad_in;
      sync2_q <= sync1_q;
    end
  end

  assign in_sync = sync2_q & den_q;
  assign pad_oe  = den_q & ((alt_q & alt_oe)  | (~alt_q & dir_q));
  assign pad_out = den_q & ((alt_q & alt_out) | (~alt_q & data_q));
  assign pad_pu  = pu_q;
  assign pad_pd  = pd_q;
  assign pin_val = den_q & ((dir_q & ~alt_q & data_q) | (~(dir_q & ~alt_q) & sync2_q));

  always_comb begin
    prdata = '0;
    if (in_data)      prdata[NPINS-1:0] = pin_val & amask;
    else if (hit_dir) prdata[NPINS-1:0] = dir_q;
    else if (hit_alt) prdata[NPINS-1:0] = alt_q;
    else if (hit_pu)  prdata[NPINS-1:0] = pu_q;
    else if (hit_pd)  prdata[NPINS-1:0] = pd_q;
    else if (hit_den) prdata[NPINS-1:0] = den_q;
  end

  assert_masked_write_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && in_data) |=> ((data_q & ~$past(amask)) == ($past(data_q) & ~$past(amask))));

  assert_den_gates_pads_R4: assert property (@(posedge clk) disable iff (!rst_n)
    ((~den_q & (pad_oe | pad_out | in_sync)) == '0));

  assert_pull_exclusive_R6: assert property (@(posedge clk) disable iff (!rst_n)
    ((pad_pu & pad_pd) == '0));

  assert_unmapped_write_ignored_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !mapped) |=> ($stable(data_q) && $stable(dir_q) && $stable(alt_q)
                            && $stable(pu_q) && $stable(pd_q) && $stable(den_q)));

  assert_unmapped_read_zero_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (psel && !mapped) |-> (prdata == '0));

  assert_sync_two_stage_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $stable(den_q) |=> (in_sync == ($past(sync1_q) & den_q)));

endmodule

// File: tb/gpio_port_regs_tb.sv
module gpio_port_regs_tb;
  logic        clk = 0;
  logic        rst_n = 0;
  logic        psel = 0, penable = 0, pwrite = 0;
  logic [11:0] paddr = '0;
  logic [31:0] pwdata = '0;
  logic [31:0] prdata;
  logic [7:0]  pad_in = '0, alt_out = '0, alt_oe = '0;
  logic [7:0]  pad_out, pad_oe, pad_pu, pad_pd, in_sync;
  int checks = 0, fails = 0;
  bit done = 0;

  always #5 clk = ~clk;

  gpio_port_regs u_dut (
    .clk(clk), .rst_n(rst_n), .psel(psel), .penable(penable), .pwrite(pwrite),
    .paddr(paddr), .pwdata(pwdata), .prdata(prdata), .pad_in(pad_in),
    .pad_out(pad_out), .pad_oe(pad_oe), .pad_pu(pad_pu), .pad_pd(pad_pd),
    .alt_out(alt_out), .alt_oe(alt_oe), .in_sync(in_sync)
  );

  // {read, addr, data-or-expected, tag}
  localparam logic [52:0] VEC [14] = '{
    {1'b0, 12'h51C, 32'h0000_00FF, 8'd4},
    {1'b0, 12'h400, 32'h0000_00FF, 8'd3},
    {1'b0, 12'h3FC, 32'h0000_00A5, 8'd1},
    {1'b1, 12'h3FC, 32'h0000_00A5, 8'd1},
    {1'b0, 12'h004, 32'h0000_0000, 8'd1},
    {1'b1, 12'h3FC, 32'h0000_00A4, 8'd1},
    {1'b0, 12'h028, 32'h0000_00FF, 8'd1},
    {1'b1, 12'h03C, 32'h0000_000E, 8'd2},
    {1'b1, 12'h3FC, 32'h0000_00AE, 8'd2},
    {1'b1, 12'h400, 32'h0000_00FF, 8'd3},
    {1'b1, 12'h404, 32'h0000_0000, 8'd8},
    {1'b0, 12'h404, 32'h0000_00FF, 8'd8},
    {1'b1, 12'h51C, 32'h0000_00FF, 8'd8},
    {1'b1, 12'h420, 32'h0000_0000, 8'd8}
  };

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic bus_write(logic [11:0] a, logic [31:0] d);
    @(negedge clk);
    psel = 1; pwrite = 1; paddr = a; pwdata = d; penable = 0;
    @(negedge clk);
    penable = 1;
    @(negedge clk);
    psel = 0; penable = 0; pwrite = 0;
  endtask

  task automatic bus_read(logic [11:0] a, output logic [31:0] d);
    @(negedge clk);
    psel = 1; pwrite = 0; paddr = a; penable = 0;
    @(negedge clk);
    penable = 1;
    #1 d = prdata;
    @(negedge clk);
    psel = 0; penable = 0;
  endtask

  function automatic string tag(int n);
    return $sformatf("R%0d", n);
  endfunction

  initial begin
    logic [31:0] rd;
    repeat (3) @(negedge clk);
    // R9: reset state
    check("R9 pad_out", {24'd0, pad_out}, 0);
    check("R9 pad_oe",  {24'd0, pad_oe}, 0);
    check("R9 pulls",   {16'd0, pad_pu, pad_pd}, 0);
    rst_n = 1;
    bus_read(12'h51C, rd); check("R4 den reset", rd, 0);
    bus_read(12'h400, rd); check("R9 dir reset", rd, 0);

    for (int i = 0; i < 14; i++) begin
      if (VEC[i][52]) begin
        bus_read(VEC[i][51:40], rd);
        check(tag(int'(VEC[i][7:0])), rd, VEC[i][39:8]);
      end else begin
        bus_write(VEC[i][51:40], VEC[i][39:8]);
      end
    end

    // R3: all pins enabled outputs with data 0xAE
    check("R3 pad_out", {24'd0, pad_out}, 32'hAE);
    check("R3 pad_oe",  {24'd0, pad_oe}, 32'hFF);

    // R7: synchronizer latency, upper nibble becomes input
    bus_write(12'h400, 32'h0F);
    @(negedge clk); pad_in = 8'hF0;
    @(negedge clk); check("R7 after one edge", {24'd0, in_sync}, 0);
    @(negedge clk); check("R7 after two edges", {24'd0, in_sync}, 32'hF0);
    bus_read(12'h3FC, rd); check("R7 R2 mixed read", rd, 32'hFE);

    // R4: disable upper nibble
    bus_write(12'h51C, 32'h0F);
    @(negedge clk);
    check("R4 pad_oe",  {24'd0, pad_oe}, 32'h0F);
    check("R4 pad_out", {24'd0, pad_out}, 32'h0E);
    check("R4 in_sync", {24'd0, in_sync}, 0);
    bus_read(12'h3FC, rd); check("R4 read gated", rd, 32'h0E);

    // R5: pins 1:0 to peripheral
    alt_out = 8'h01; alt_oe = 8'h02;
    bus_write(12'h420, 32'h03);
    @(negedge clk);
    check("R5 pad_oe",  {24'd0, pad_oe}, 32'h0E);
    check("R5 pad_out", {24'd0, pad_out}, 32'h0D);

    // R6: pull exclusivity
    bus_write(12'h510, 32'h3C);
    bus_write(12'h514, 32'h30);
    check("R6 pu", {24'd0, pad_pu}, 32'h0C);
    check("R6 pd", {24'd0, pad_pd}, 32'h30);
    bus_write(12'h510, 32'h10);
    check("R6 pu again", {24'd0, pad_pu}, 32'h10);
    check("R6 pd again", {24'd0, pad_pd}, 32'h20);
    bus_read(12'h514, rd); check("R6 pd readback", rd, 32'h20);

    // R8: unmapped write leaves pads unchanged
    bus_write(12'h600, 32'hFF);
    check("R8 pad_out", {24'd0, pad_out}, 32'h0D);
    bus_read(12'h600, rd); check("R8 read zero", rd, 0);

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end
endmodule